// File: doc/BRIEF.md
# Paged Receive Ring Manager

This block stores incoming frames in a circular buffer of 256-byte pages held in local memory. Two configuration values bound the ring: the first page that belongs to it and the page just past its end. A host-owned boundary page marks the last page the host has not yet released. The block keeps a current-page register that points to where the next frame will begin.

Each frame begins at offset 4 of the current page. The bytes arrive on a simple byte stream that carries a last-byte flag and error flags, and they go out one per cycle on a registered memory write port. When the frame ends, the block decides whether to keep it. A kept frame gets a 4-byte header written into offsets 0 to 3 of its first page. The current page then moves to the page after the one that holds the final byte, wrapping from the end of the ring back to its first page, and a one-cycle completion pulse is raised.

A frame is dropped if it is short, if it has errors and saving of errored frames is off, or if storing it would run the ring into the boundary page. In the last case an overwrite warning flag is set and stays set until the host clears it. While the flag is set, no frame is stored.

Top module: `rx_page_ring`

## Requirements
- R1: During and just after reset, `cur_page` equals `ring_first`, `ovw_flag` is 0, `frame_done` is 0 and `mem_we` is 0.
- R2: Frame byte j (counting from 0) is written one cycle after it is accepted. It goes to the byte at linear offset 4+j from the start of the current page: offset bits [7:0] of `mem_addr`, page in bits [15:8], with successive pages taken in ring order.
- R3: The page that follows page `ring_limit`-1 is `ring_first`, both for data writes and for the next-page pointer. Every write lands inside [`ring_first`, `ring_limit`).
- R4: A kept frame's header goes to offsets 0,1,2,3 of its first page, in the cycles after its last byte. The four bytes are status, next page, length bits [7:0] and length bits [15:8].
- R5: Status byte encoding: bit 0 is set when `in_err` is all zero (frame intact). Bit 1 copies `in_err[0]` (CRC error), bit 2 copies `in_err[1]` (alignment error) and bit 3 copies `in_err[2]` (FIFO overrun). Bits 7:4 are 0. `in_err` is sampled with the last byte.
- R6: The stored length counts every byte of the frame, FCS included. The next-page field is the ring successor of the page that holds the last byte, so a frame that fills its last page exactly is followed by the next page.
- R7: For a kept frame, `cur_page` takes the next-page value and `frame_done` is high for exactly one cycle. Both happen in the same cycle as the write of header byte 3.
- R8: A frame with any `in_err` bit set is dropped when `save_bad` is 0: `cur_page` does not change and no `frame_done` pulse occurs. With `save_bad` 1 the frame is kept.
- R9: A frame shorter than 64 bytes (FCS included) is always dropped, whatever `save_bad` is.
- R10: If a data write would cross into the page equal to `host_bound`, `ovw_flag` is set. No further byte of that frame is written, no header is written, and `cur_page` does not change.
- R11: While `ovw_flag` is set, incoming frames produce no memory writes. A one-cycle `ovw_clr` clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_first | input | 8 | First page of the ring |
| ring_limit | input | 8 | Page just past the end of the ring |
| host_bound | input | 8 | Boundary page still owned by the host |
| save_bad | input | 1 | Keep frames that carry error flags |
| in_valid | input | 1 | A frame byte is present |
| in_byte | input | 8 | Frame byte |
| in_last | input | 1 | This byte ends the frame |
| in_err | input | 3 | Error flags with the last byte: [0] CRC, [1] alignment, [2] FIFO overrun |
| ovw_clr | input | 1 | Clears the overwrite warning |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory byte address {page, offset} |
| mem_wdata | output | 8 | Memory write data |
| cur_page | output | 8 | Page where the next frame will start |
| frame_done | output | 1 | One-cycle pulse when a frame has been stored |
| ovw_flag | output | 1 | Overwrite warning |

## Verification
The bench sends one frame that exactly fills the rest of its page. A design that computes the next page from the byte pointer instead of from the last byte's page would skip a page or reuse one. One long frame runs past the end of the ring, and a byte is checked at the first page of the ring: an off-by-one in the wrap would put that byte at `ring_limit` or corrupt the header pointer. Errored, saved-errored and 63-byte frames each check whether the current page moves and whether the completion pulse fires. Finally, a frame runs into the boundary page. The bench counts exactly how many bytes get written before the stop, then confirms that a frame sent while the warning is set writes nothing.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int HDR_BYTES = 4;
  localparam int MIN_FRAME = 64;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_DROP = 2'd2,
    ST_HDR  = 2'd3
  } ring_state_t;
endpackage

// File: rtl/ring_page_step.sv
module ring_page_step #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] pg,
  input  logic [PW-1:0] first,
  input  logic [PW-1:0] limit,
  output logic [PW-1:0] nxt
);
  logic [PW-1:0] inc;
  always_comb begin
    inc = pg + 1'b1;
    nxt = (inc == limit) ? first : inc;
  end
endmodule

// File: rtl/ring_hdr_mux.sv
module ring_hdr_mux #(
  parameter int PW = 8,
  parameter int LW = 16
) (
  input  logic [1:0]    idx,
  input  logic [7:0]    stat,
  input  logic [PW-1:0] nxt,
  input  logic [LW-1:0] len,
  output logic [7:0]    byte_o
);
  always_comb begin
    case (idx)
      2'd0:    byte_o = stat;
      2'd1:    byte_o = 8'(nxt);
      2'd2:    byte_o = len[7:0];
      default: byte_o = len[15:8];
    endcase
  end
endmodule

// File: rtl/ring_wr_port.sv
module ring_wr_port #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [7:0]    wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      we    <= 1'b0;
      addr  <= '0;
      wdata <= '0;
    end else begin
      we    <= req_we;
      addr  <= req_addr;
      wdata <= req_data;
    end
  end
endmodule

// File: rtl/rx_page_ring.sv
module rx_page_ring
  import ring_pkg::*;
#(
  parameter int PW = 8,
  parameter int OW = 8,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] ring_first,
  input  logic [PW-1:0] ring_limit,
  input  logic [PW-1:0] host_bound,
  input  logic          save_bad,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          in_last,
  input  logic [2:0]    in_err,
  input  logic          ovw_clr,
  output logic          mem_we,
  output logic [PW+OW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic [PW-1:0] cur_page,
  output logic          frame_done,
  output logic          ovw_flag
);
  localparam int AW = PW + OW;
  localparam logic [OW-1:0] OFF_FIRST = OW'(HDR_BYTES);
  localparam logic [OW-1:0] OFF_END   = {OW{1'b1}};
  localparam logic [LW-1:0] LEN_MIN   = LW'(MIN_FRAME);

  ring_state_t   state;
  logic [PW-1:0] cur_q, ptr_pg, hdr_next, step_pg;
  logic [OW-1:0] ptr_off;
  logic [LW-1:0] len_cnt, hdr_len, len_n;
  logic [7:0]    hdr_stat, hdr_byte;
  logic [1:0]    hdr_idx;
  logic          done_q, ovw_q;
  logic          req_we;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_data;
  logic          crossing, overrun, keep;

  ring_page_step #(.PW(PW)) u_step (
    .pg(ptr_pg), .first(ring_first), .limit(ring_limit), .nxt(step_pg)
  );

  ring_hdr_mux #(.PW(PW), .LW(LW)) u_hdr (
    .idx(hdr_idx), .stat(hdr_stat), .nxt(hdr_next), .len(hdr_len), .byte_o(hdr_byte)
  );

  ring_wr_port #(.AW(AW)) u_port (
    .clk(clk), .rst(rst), .req_we(req_we), .req_addr(req_addr), .req_data(req_data),
    .we(mem_we), .addr(mem_addr), .wdata(mem_wdata)
  );

  always_comb begin
    len_n    = len_cnt + 1'b1;
    crossing = (ptr_off == OFF_END);
    overrun  = crossing && (step_pg == host_bound);
    keep     = (len_n >= LEN_MIN) && ((in_err == 3'b000) || save_bad);
    req_we   = 1'b0;
    req_addr = {ptr_pg, ptr_off};
    req_data = in_byte;
    case (state)
      ST_IDLE: begin
        req_we   = in_valid && !ovw_q;
        req_addr = {cur_q, OFF_FIRST};
      end
      ST_RECV: req_we = in_valid;
      ST_HDR: begin
        req_we   = 1'b1;
        req_addr = {cur_q, OW'(hdr_idx)};
        req_data = hdr_byte;
      end
      default: req_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_q    <= ring_first;
      ptr_pg   <= ring_first;
      ptr_off  <= OFF_FIRST;
      len_cnt  <= '0;
      hdr_len  <= '0;
      hdr_stat <= '0;
      hdr_next <= ring_first;
      hdr_idx  <= '0;
      done_q   <= 1'b0;
      ovw_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ovw_clr) ovw_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            if (ovw_q) begin
              if (!in_last) state <= ST_DROP;
            end else begin
              ptr_pg  <= cur_q;
              ptr_off <= OFF_FIRST + 1'b1;
              len_cnt <= LW'(1);
              if (!in_last) state <= ST_RECV;
            end
          end
        end
        ST_RECV: begin
          if (in_valid) begin
            len_cnt <= len_n;
            if (crossing) begin
              ptr_pg  <= step_pg;
              ptr_off <= '0;
            end else begin
              ptr_off <= ptr_off + 1'b1;
            end
            if (overrun) begin
              ovw_q <= 1'b1;
              state <= in_last ? ST_IDLE : ST_DROP;
            end else if (in_last) begin
              hdr_stat <= {4'b0000, in_err, (in_err == 3'b000)};
              hdr_next <= step_pg;
              hdr_len  <= len_n;
              hdr_idx  <= '0;
              state    <= keep ? ST_HDR : ST_IDLE;
            end
          end
        end
        ST_DROP: begin
          if (in_valid && in_last) state <= ST_IDLE;
        end
        default: begin
          hdr_idx <= hdr_idx + 1'b1;
          if (hdr_idx == 2'd3) begin
            cur_q  <= hdr_next;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign cur_page   = cur_q;
  assign frame_done = done_q;
  assign ovw_flag   = ovw_q;

  AST_CUR_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_page) |-> frame_done); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R7
  AST_WRITE_IN_RING: assert property (@(posedge clk) disable iff (rst)
    (mem_we && (ring_first < ring_limit)) |->
      ((mem_addr[AW-1:OW] >= ring_first) && (mem_addr[AW-1:OW] < ring_limit))); // R3
  AST_OVW_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovw_flag && !ovw_clr) |=> ovw_flag); // R11
  AST_SILENT_WHILE_OVW: assert property (@(posedge clk) disable iff (rst)
    $past(ovw_q) |-> !mem_we); // R11
  AST_NEXT_IN_RING: assert property (@(posedge clk) disable iff (rst)
    (frame_done && (ring_first < ring_limit)) |->
      ((cur_page >= ring_first) && (cur_page < ring_limit))); // R6
endmodule

// File: tb/sim_rx_page_ring.sv
module sim_rx_page_ring;
  logic clk = 1'b0;
  logic rst;
  logic [7:0] ring_first, ring_limit, host_bound;
  logic save_bad, in_valid, in_last, ovw_clr;
  logic [7:0] in_byte;
  logic [2:0] in_err;
  logic mem_we, frame_done, ovw_flag;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, cur_page;

  always #5 clk = ~clk;

  rx_page_ring u0 (
    .clk(clk), .rst(rst), .ring_first(ring_first), .ring_limit(ring_limit),
    .host_bound(host_bound), .save_bad(save_bad), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .in_err(in_err), .ovw_clr(ovw_clr), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_page(cur_page),
    .frame_done(frame_done), .ovw_flag(ovw_flag)
  );

  localparam int NF = 7;
  localparam int T_LEN  [NF] = '{64, 252, 300, 300, 600, 63, 100};
  localparam int T_ERR  [NF] = '{0,  0,   1,   1,   0,   0,  6};
  localparam int T_SAVE [NF] = '{0,  0,   0,   1,   0,   0,  1};
  localparam int T_KEEP [NF] = '{1,  1,   0,   1,   1,   0,  1};
  localparam int T_NEXT [NF] = '{3,  4,   4,   6,   3,   3,  4};
  localparam int T_STAT [NF] = '{1,  1,   0,   2,   1,   0,  12};

  logic [7:0] bmem [0:2047];
  int wr_cnt, done_cnt, total, bad;
  bit finished;

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      bmem[mem_addr[10:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (!rst && frame_done) done_cnt <= done_cnt + 1;
  end

  function automatic logic [7:0] pat(input int j, input int f);
    return 8'((j * 7 + f * 13) & 255);
  endfunction

  function automatic int byte_addr(input int start, input int j);
    int lin, pg;
    lin = 4 + j;
    pg = start + lin / 256;
    if (pg >= 8) pg = pg - 6;
    return pg * 256 + (lin % 256);
  endfunction

  function automatic int prev_pg(input int p);
    return (p == 2) ? 7 : p - 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int len, input int err, input int f);
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = pat(j, f);
      in_last  = (j == len - 1);
      in_err   = (j == len - 1) ? 3'(err) : 3'b000;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_err = 3'b000;
    repeat (10) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cur_e, d0, st;
    for (int i = 0; i < 2048; i++) bmem[i] = 8'h00;
    total = 0; bad = 0; wr_cnt = 0; done_cnt = 0; finished = 1'b0;
    rst = 1'b1; ring_first = 8'd2; ring_limit = 8'd8; host_bound = 8'd7;
    save_bad = 1'b0; in_valid = 1'b0; in_byte = 8'h00; in_last = 1'b0;
    in_err = 3'b000; ovw_clr = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 cur_page in reset", int'(cur_page), 2);
    rst = 1'b0;
    @(negedge clk);
    check("R1 cur_page", int'(cur_page), 2);
    check("R1 ovw_flag", int'(ovw_flag), 0);
    check("R1 frame_done", int'(frame_done), 0);
    check("R1 mem_we", int'(mem_we), 0);

    cur_e = 2;
    for (int f = 0; f < NF; f++) begin
      host_bound = 8'(prev_pg(cur_e));
      save_bad = T_SAVE[f][0];
      d0 = done_cnt;
      st = cur_e;
      send(T_LEN[f], T_ERR[f], f);
      if (T_KEEP[f] != 0) cur_e = T_NEXT[f];
      check($sformatf("R7 R8 R9 cur_page frame %0d", f), int'(cur_page), cur_e);
      check($sformatf("R7 R8 R9 done pulses frame %0d", f), done_cnt - d0, T_KEEP[f]);
      if (T_KEEP[f] != 0) begin
        check($sformatf("R4 R5 status frame %0d", f), int'(bmem[st*256]), T_STAT[f]);
        check($sformatf("R4 R6 next frame %0d", f), int'(bmem[st*256+1]), T_NEXT[f]);
        check($sformatf("R4 R6 len lo frame %0d", f), int'(bmem[st*256+2]), T_LEN[f] & 255);
        check($sformatf("R4 R6 len hi frame %0d", f), int'(bmem[st*256+3]), T_LEN[f] >> 8);
        check($sformatf("R2 first byte frame %0d", f), int'(bmem[st*256+4]), int'(pat(0, f)));
        check($sformatf("R2 last byte frame %0d", f),
              int'(bmem[byte_addr(st, T_LEN[f]-1)]), int'(pat(T_LEN[f]-1, f)));
      end
      if (f == 4)
        check("R3 wrapped byte at ring_first", int'(bmem[512]), int'(pat(508, f)));
    end

    // R10: boundary at page 5, frame from page 4 must stop at the crossing
    host_bound = 8'd5; save_bad = 1'b0;
    wr_cnt = 0; d0 = done_cnt;
    send(300, 0, 9);
    check("R10 ovw_flag set", int'(ovw_flag), 1);
    check("R10 writes before stop", wr_cnt, 252);
    check("R10 cur_page held", int'(cur_page), 4);
    check("R10 no done", done_cnt - d0, 0);

    // R11: frame while warning set writes nothing
    wr_cnt = 0;
    send(64, 0, 10);
    check("R11 no writes while ovw", wr_cnt, 0);
    check("R11 ovw still set", int'(ovw_flag), 1);
    @(negedge clk); ovw_clr = 1'b1;
    @(negedge clk); ovw_clr = 1'b0;
    check("R11 ovw cleared", int'(ovw_flag), 0);

    host_bound = 8'd3; d0 = done_cnt;
    send(64, 0, 11);
    check("R11 store after clear cur_page", int'(cur_page), 5);
    check("R11 store after clear done", done_cnt - d0, 1);
    check("R5 status after clear", int'(bmem[4*256]), 1);
    check("R2 byte after clear", int'(bmem[4*256+4]), int'(pat(0, 11)));

    finish_run();
  end
endmodule